// File: doc/BRIEF.md
# Programmable Peripheral Bus Cycle Sequencer

This block runs one access on an asynchronous external peripheral bus for a bank that an address decoder upstream has already picked. A requester presents an address, a read or write flag, write data and byte enables. The sequencer then steps the bus through an address phase, a chip-select delay, a strobe delay, a strobe phase and a hold phase. Each phase length is a clock count taken from a per-bank timing parameter input. A read strobe may be stretched by an external ready line, with a timeout guarding against a device that never answers. A write strobe can be cut short a programmable number of clocks before its end. This gives a narrower write pulse than read pulse inside the same cycle frame.

The timing parameters and the request are captured on the clock edge that accepts the request, so the parameter source may change during an access. The access permissions are checked on that same edge. A denied request skips the bus entirely and finishes at once with an error. Every access ends with a one-clock done pulse. For reads, that pulse carries the captured data.

States:
- `ST_IDLE` waits for a request.
- `ST_ADDR` drives the address for one clock.
- `ST_CSDLY` counts the chip-select delay.
- `ST_STBDLY` asserts chip select and counts the strobe delay.
- `ST_STROBE` asserts the read or write strobe and counts the wait length, then waits for ready.
- `ST_HOLD` keeps chip select low after the strobe.
- `ST_DONE` signals completion.

Transitions:
- `ST_IDLE` to `ST_ADDR` on an allowed request, or to `ST_DONE` on a denied one.
- `ST_ADDR` to the first non-empty phase among `ST_CSDLY`, `ST_STBDLY` and `ST_STROBE`.
- `ST_CSDLY` to `ST_STBDLY` or `ST_STROBE` when its count expires.
- `ST_STBDLY` to `ST_STROBE`.
- `ST_STROBE` to `ST_HOLD`, or to `ST_DONE` when the hold count is zero.
- `ST_HOLD` to `ST_DONE`.
- `ST_DONE` to `ST_IDLE`.

Top module: `pbus_seq`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_oe_n` and `bus_we_n` are high, `bus_be_n` is all ones, `rsp_done` is low and `req_ready` is high.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Counting the first clock after that edge as cycle 0 (the address cycle, with no strobes), chip select first goes low in cycle 1 + `cfg_cs_dly`.
- R3: The strobe goes low `cfg_stb_dly` cycles after chip select does. The strobe is `bus_oe_n` for a read and `bus_we_n` for a write. With a zero delay, it falls together with chip select.
- R4: With ready sampling off, a read strobe lasts `cfg_wait` + 1 clocks.
- R5: With `cfg_rdy_en` set, the strobe lasts at least `cfg_wait` + 1 clocks. It then ends at the first rising edge, from the last counted clock on, at which `bus_rdy` is high.
- R6: With `cfg_rdy_en` set, if `bus_rdy` stays low for TMO clocks after the wait count has run out, the strobe ends after `cfg_wait` + TMO clocks. The access then completes with `rsp_err` high, and the hold phase is still performed.
- R7: With ready sampling off, the write strobe lasts max(1, `cfg_wait` + 1 − `cfg_we_early`) clocks, starting in the same cycle a read strobe would.
- R8: Chip select stays low for `cfg_hold` clocks after the strobe ends (zero allowed). `rsp_done` is high for exactly one clock, in the cycle right after chip select rises. That cycle is cycle 1 + `cfg_cs_dly` + `cfg_stb_dly` + strobe length + `cfg_hold`.
- R9: `rsp_rdata` at the done pulse holds the `bus_din` value sampled on the rising edge that ends the last read-strobe clock.
- R10: A read with `cfg_rd_ok` low, or a write with `cfg_wr_ok` low, gives `rsp_done` with `rsp_err` high in cycle 0. Chip select and both strobes stay high throughout.
- R11: While chip select is low, several outputs hold the accepted request. `bus_addr` equals the request address. `bus_io` equals address bit IO_BIT (1 = I/O cycle, 0 = memory cycle). `bus_be_n` equals the inverted request byte enables. For writes, `bus_doe` is high and `bus_dout` equals the write data.
- R12: Changing any `cfg_*` input after the accepting edge does not change the timing, permission or result of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| cfg_cs_dly | input | CW | Clocks from address phase end to chip select |
| cfg_stb_dly | input | CW | Clocks from chip select to strobe |
| cfg_wait | input | CW | Strobe length minus one |
| cfg_we_early | input | CW | Clocks by which the write strobe ends early |
| cfg_hold | input | CW | Clocks chip select stays low after the strobe |
| cfg_rdy_en | input | 1 | Extend the strobe until ready |
| cfg_rd_ok | input | 1 | Bank allows reads |
| cfg_wr_ok | input | 1 | Bank allows writes |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable (read strobe), active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_be_n | output | DW/8 | Byte enables, active low |
| bus_addr | output | AW | Bus address |
| bus_io | output | 1 | Cycle type qualifier, 1 = I/O cycle |
| bus_dout | output | DW | Write data to the bus |
| bus_doe | output | 1 | Data output drive enable |
| bus_din | input | DW | Read data from the bus |
| bus_rdy | input | 1 | External ready |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Error qualifier of the done pulse |
| rsp_rdata | output | DW | Read data |

## Verification
The embedded properties assume a few things about the stimulus:
- The requester does not present a new request before `req_ready` returns.
- `bus_rdy` and `bus_din` are driven to known values whenever the strobe is active.
- The phase counter is only decremented while non-zero, which relies on the state machine consulting the zero flag.

The stimulus keeps to these assumptions. It drives every input half a clock away from the active edge, waits for the done pulse before issuing the next request, and raises ready only inside an access. Once raised, ready stays high until the next request.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CSDLY,
        ST_STBDLY,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } pbus_state_e;

endpackage

// File: rtl/pbus_cnt.sv
module pbus_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign value = cnt_q;
    assign zero  = (cnt_q == '0);

    // R2 R3 R4 R8
    cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/pbus_tmo.sv
module pbus_tmo #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic hit
);

    localparam int TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [TW-1:0] t_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else if (clr) begin
            t_q <= '0;
        end else if (step) begin
            t_q <= t_q + 1'b1;
        end
    end

    assign hit = (t_q == TW'(LIMIT - 1));

    // R6
    tmo_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (t_q != '0));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int CW     = 4,
    parameter int TMO    = 256,
    parameter int IO_BIT = AW - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_be,
    input  logic [CW-1:0]   cfg_cs_dly,
    input  logic [CW-1:0]   cfg_stb_dly,
    input  logic [CW-1:0]   cfg_wait,
    input  logic [CW-1:0]   cfg_we_early,
    input  logic [CW-1:0]   cfg_hold,
    input  logic            cfg_rdy_en,
    input  logic            cfg_rd_ok,
    input  logic            cfg_wr_ok,
    output logic            bus_cs_n,
    output logic            bus_oe_n,
    output logic            bus_we_n,
    output logic [DW/8-1:0] bus_be_n,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_io,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_doe,
    input  logic [DW-1:0]   bus_din,
    input  logic            bus_rdy,
    output logic            rsp_done,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata
);

    localparam int BW = DW / 8;

    pbus_state_e state, nstate;

    logic          l_write, l_rdy, err_q;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_wdata, rdata_q;
    logic [BW-1:0] l_be;
    logic [CW-1:0] l_csd, l_sd, l_wt, l_wbe, l_hold;

    logic          req_ok;
    logic          cnt_load, cnt_dec, cnt_zero;
    logic [CW-1:0] cnt_val, cnt_q;
    logic          tmo_clr, tmo_step, tmo_hit;
    logic          stb_end, stb_timeout;
    logic          cs_on, stb_on;

    pbus_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .value    (cnt_q),
        .zero     (cnt_zero)
    );

    pbus_tmo #(.LIMIT(TMO)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmo_clr),
        .step  (tmo_step),
        .hit   (tmo_hit)
    );

    assign req_ok = req_write ? cfg_wr_ok : cfg_rd_ok;

    // next state and phase counter control
    always_comb begin
        nstate      = state;
        cnt_load    = 1'b0;
        cnt_val     = '0;
        cnt_dec     = 1'b0;
        tmo_clr     = 1'b0;
        tmo_step    = 1'b0;
        stb_end     = 1'b0;
        stb_timeout = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nstate = req_ok ? ST_ADDR : ST_DONE;
            end
            ST_ADDR: begin
                cnt_load = 1'b1;
                if (l_csd != '0) begin
                    nstate  = ST_CSDLY;
                    cnt_val = l_csd - 1'b1;
                end else if (l_sd != '0) begin
                    nstate  = ST_STBDLY;
                    cnt_val = l_sd - 1'b1;
                end else begin
                    nstate  = ST_STROBE;
                    cnt_val = l_wt;
                    tmo_clr = 1'b1;
                end
            end
            ST_CSDLY: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (l_sd != '0) begin
                    nstate   = ST_STBDLY;
                    cnt_load = 1'b1;
                    cnt_val  = l_sd - 1'b1;
                end else begin
                    nstate   = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = l_wt;
                    tmo_clr  = 1'b1;
                end
            end
            ST_STBDLY: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else begin
                    nstate   = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = l_wt;
                    tmo_clr  = 1'b1;
                end
            end
            ST_STROBE: begin
                if (!cnt_zero) begin
                    cnt_dec = 1'b1;
                end else if (!l_rdy || bus_rdy) begin
                    stb_end = 1'b1;
                end else if (tmo_hit) begin
                    stb_end     = 1'b1;
                    stb_timeout = 1'b1;
                end else begin
                    tmo_step = 1'b1;
                end
                if (stb_end) begin
                    if (l_hold != '0) begin
                        nstate   = ST_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = l_hold - 1'b1;
                    end else begin
                        nstate = ST_DONE;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) nstate = ST_DONE;
                else          cnt_dec = 1'b1;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register and per-access capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            l_write <= 1'b0;
            l_rdy   <= 1'b0;
            l_addr  <= '0;
            l_wdata <= '0;
            l_be    <= '0;
            l_csd   <= '0;
            l_sd    <= '0;
            l_wt    <= '0;
            l_wbe   <= '0;
            l_hold  <= '0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= nstate;
            if (state == ST_IDLE && req_valid) begin
                l_write <= req_write;
                l_addr  <= req_addr;
                l_wdata <= req_wdata;
                l_be    <= req_be;
                l_csd   <= cfg_cs_dly;
                l_sd    <= cfg_stb_dly;
                l_wt    <= cfg_wait;
                l_wbe   <= cfg_we_early;
                l_hold  <= cfg_hold;
                l_rdy   <= cfg_rdy_en;
                err_q   <= !req_ok;
            end
            if (stb_end && !l_write) rdata_q <= bus_din;
            if (stb_timeout)         err_q   <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cs_on     = (state == ST_STBDLY) || (state == ST_STROBE) || (state == ST_HOLD);
        stb_on    = (state == ST_STROBE);
        req_ready = (state == ST_IDLE);
        bus_cs_n  = !cs_on;
        bus_oe_n  = !(stb_on && !l_write);
        bus_we_n  = !(stb_on && l_write && ((cnt_q >= l_wbe) || (cnt_q == l_wt)));
        bus_be_n  = cs_on ? ~l_be : '1;
        bus_addr  = l_addr;
        bus_io    = (state != ST_IDLE) && l_addr[IO_BIT];
        bus_dout  = l_wdata;
        bus_doe   = cs_on && l_write;
        rsp_done  = (state == ST_DONE);
        rsp_err   = (state == ST_DONE) && err_q;
        rsp_rdata = rdata_q;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> rsp_done);

    // R3
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

    // R7
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_addr) && $stable(bus_io)));

    // R10
    deny_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !(req_write ? cfg_wr_ok : cfg_rd_ok)) |=> (rsp_done && rsp_err && bus_cs_n));

endmodule

// File: tb/test_pbus_seq.sv
`timescale 1ns/1ps
module test_pbus_seq;

    localparam int TMO = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [3:0]  cfg_cs_dly = '0, cfg_stb_dly = '0, cfg_wait = '0, cfg_we_early = '0, cfg_hold = '0;
    logic        cfg_rdy_en = 1'b0, cfg_rd_ok = 1'b1, cfg_wr_ok = 1'b1;
    logic        bus_cs_n, bus_oe_n, bus_we_n, bus_io, bus_doe;
    logic [1:0]  bus_be_n;
    logic [15:0] bus_addr, bus_dout, rsp_rdata;
    logic [15:0] bus_din = '0;
    logic        bus_rdy = 1'b0;
    logic        rsp_done, rsp_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pbus_seq i_pbus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_cs_dly(cfg_cs_dly), .cfg_stb_dly(cfg_stb_dly), .cfg_wait(cfg_wait),
        .cfg_we_early(cfg_we_early), .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en),
        .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_be_n(bus_be_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one access; rdy_at = 0 with rdy_en means ready never comes
    task automatic run(input int csd, input int sd, input int wt, input int wbe, input int hold,
                       input bit wr, input bit rdy_en, input int rdy_at,
                       input bit rd_ok, input bit wr_ok, input bit perturb,
                       input logic [15:0] addr);
        int t = 0;
        int first_cs = -1, first_stb = -1, cs_cnt = 0, oe_cnt = 0, we_cnt = 0;
        int t_done = -1, bad = 0;
        int w, exp_we, exp_err;
        bit err_seen = 0, fin = 0, allowed;
        logic [15:0] rdata = '0;
        logic [15:0] wdata = addr ^ 16'h5A3C;
        logic [1:0]  be = addr[1:0] | 2'b01;

        @(negedge clk);
        cfg_cs_dly = 4'(csd); cfg_stb_dly = 4'(sd); cfg_wait = 4'(wt);
        cfg_we_early = 4'(wbe); cfg_hold = 4'(hold); cfg_rdy_en = rdy_en;
        cfg_rd_ok = rd_ok; cfg_wr_ok = wr_ok;
        req_write = wr; req_addr = addr; req_wdata = wdata; req_be = be;
        req_valid = 1'b1; bus_rdy = 1'b0;
        @(posedge clk);
        while (!fin) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (perturb && t == 0) begin
                cfg_cs_dly = 4'(csd + 3); cfg_stb_dly = 4'(sd + 2); cfg_wait = 4'(wt + 4);
                cfg_hold = 4'(hold + 5); cfg_rdy_en = !rdy_en;
                cfg_rd_ok = !rd_ok; cfg_wr_ok = !wr_ok;
            end
            if (!bus_cs_n) begin
                if (first_cs < 0) first_cs = t;
                cs_cnt++;
                if (bus_addr != addr || bus_io != addr[15] || bus_be_n != ~be) bad++;
                if (wr && (!bus_doe || bus_dout != wdata)) bad++;
                if (!wr && bus_doe) bad++;
            end
            if (!bus_oe_n) begin
                if (first_stb < 0) first_stb = t;
                oe_cnt++;
                bus_din = 16'hA000 + 16'(oe_cnt);
                if (rdy_en && oe_cnt == rdy_at) bus_rdy = 1'b1;
            end
            if (!bus_we_n) begin
                if (first_stb < 0) first_stb = t;
                we_cnt++;
            end
            if (rsp_done) begin
                t_done = t; err_seen = rsp_err; rdata = rsp_rdata; fin = 1;
            end else begin
                t++;
                if (t > 2000) fin = 1;
            end
        end
        @(negedge clk);
        check("R8", "done width", int'(rsp_done), 0);
        bus_rdy = 1'b0;

        allowed = wr ? wr_ok : rd_ok;
        if (!allowed) begin
            check("R10", "done cycle", t_done, 0);
            check("R10", "err", int'(err_seen), 1);
            check("R10", "cs cycles", cs_cnt, 0);
            check("R10", "strobe cycles", oe_cnt + we_cnt, 0);
        end else begin
            if (!rdy_en)          w = wt + 1;
            else if (rdy_at == 0) w = wt + TMO;
            else                  w = (rdy_at > wt + 1) ? rdy_at : wt + 1;
            exp_err = (rdy_en && rdy_at == 0) ? 1 : 0;
            exp_we  = (wt + 1 - wbe > 1) ? wt + 1 - wbe : 1;
            check(perturb ? "R12" : "R2", "cs start", first_cs, 1 + csd);
            check(perturb ? "R12" : "R3", "strobe start", first_stb, 1 + csd + sd);
            if (wr) begin
                check("R7", "we cycles", we_cnt, exp_we);
                check("R7", "oe during write", oe_cnt, 0);
            end else begin
                check(rdy_en ? (exp_err ? "R6" : "R5") : "R4", "oe cycles", oe_cnt, w);
                check("R9", "rdata", int'(rdata), int'(16'hA000 + 16'(w)));
            end
            check(perturb ? "R12" : "R8", "cs cycles", cs_cnt, sd + w + hold);
            check(perturb ? "R12" : "R8", "done cycle", t_done, 1 + csd + sd + w + hold);
            check(exp_err ? "R6" : "R10", "err", int'(err_seen), exp_err);
            check("R11", "held bus values", bad, 0);
        end
    endtask

    initial begin : watchdog
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "cs_n", int'(bus_cs_n), 1);
        check("R1", "oe_n", int'(bus_oe_n), 1);
        check("R1", "we_n", int'(bus_we_n), 1);
        check("R1", "be_n", int'(bus_be_n), 3);
        check("R1", "done", int'(rsp_done), 0);
        check("R1", "ready", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ready after reset", int'(req_ready), 1);

        // R2 R3 R4 R7 R8 sweep
        for (int csd = 0; csd < 3; csd++)
            for (int sd = 0; sd < 3; sd++)
                for (int wt = 0; wt < 3; wt++)
                    for (int hold = 0; hold < 3; hold++)
                        for (int wr = 0; wr < 2; wr++)
                            run(csd, sd, wt, hold + wr, hold, wr[0], 0, 0, 1, 1, 0,
                                16'(16'h1230 + (csd << 14) + (sd << 15) + wt * 4 + hold));

        // longer settings: 30 ns clock example and setup/length/hold sets
        run(3, 1, 7, 0, 7, 0, 0, 0, 1, 1, 0, 16'h8004);
        run(3, 1, 7, 5, 7, 1, 0, 0, 1, 1, 0, 16'h8006);
        run(2, 1, 5, 0, 1, 0, 0, 0, 1, 1, 0, 16'h0100);
        run(1, 1, 4, 0, 1, 0, 0, 0, 1, 1, 0, 16'h0102);
        run(0, 1, 3, 0, 1, 1, 0, 0, 1, 1, 0, 16'h0104);
        run(0, 1, 2, 0, 1, 0, 0, 0, 1, 1, 0, 16'h0106);
        // R7 early deassert larger than the strobe
        run(1, 0, 2, 9, 1, 1, 0, 0, 1, 1, 0, 16'h4008);

        // R5 ready extension
        run(0, 1, 2, 0, 1, 0, 1, 6, 1, 1, 0, 16'h2000);
        run(1, 0, 3, 0, 0, 0, 1, 1, 1, 1, 0, 16'hA000);
        run(0, 0, 0, 0, 2, 0, 1, 2, 1, 1, 0, 16'h2002);
        // R6 timeout
        run(1, 1, 1, 0, 2, 0, 1, 0, 1, 1, 0, 16'h9000);

        // R10 permission
        run(1, 1, 1, 0, 1, 0, 0, 0, 0, 1, 0, 16'h3000);
        run(1, 1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 16'h3002);
        run(0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 16'hF00E);

        // R12 configuration changes during the access
        run(2, 1, 3, 0, 2, 0, 0, 0, 1, 1, 1, 16'h7010);
        run(1, 2, 2, 1, 1, 1, 0, 0, 1, 1, 1, 16'hC012);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule